// File: doc/BRIEF.md
# Pulse-Swallow Divider Controller

This block is the digital half of a synthesizer feedback divider built as a main counter M and a swallow counter A around an external prescaler. The prescaler divides by 16 or by 17, as chosen by a modulus-select line. The block is clocked by the prescaler output. In each divide cycle it counts M prescaler periods and asks for divide-by-17 during the first A of them. One divide cycle therefore spans 17·A + 16·(M − A) = 16·M + A input periods. It marks the end of each cycle with a single divided-output pulse.

The 15-bit divide word arrives as two halves, each with its own write strobe. The halves are collected in a staging register and cannot act until both have been supplied. A completed word is range-checked. If accepted, it waits in a pending register and moves into the counters only at the end of a divide cycle, so a running cycle is never cut short or stretched by a half-written or mid-cycle update. Below the lowest legal ratio the word is refused, and the ratio in use is kept.

Top module: `pswd_divider_ctrl`

## Requirements
- R1: While and after a synchronous reset, `modSel`, `divPulse` and `wordReject` are 0. No pulse appears until a valid word has been completed.
- R2: The divide word is {`hiData`, `loData`}, with `hiData` holding word bits 14:8 and `loData` holding bits 7:0. The swallow count A is word bits 3:0 and the main count M is word bits 14:4. Successive `divPulse` pulses are exactly M clocks apart, which covers every word from 240 to 32767.
- R3: In every divide cycle `modSel` (1 = divide by 17) is high for exactly the first A clocks and low for the remaining M − A clocks.
- R4: `divPulse` is one clock wide and is high in the last clock of each divide cycle.
- R5: A word is complete only once both halves have been written since the previous completion, in either order. A single half write leaves the running ratio unchanged.
- R6: Writing both halves in the same clock completes the word in that clock.
- R7: A completed word below 240 makes `wordReject` high for the one clock following the completing edge. The ratio in use is unchanged.
- R8: An accepted word does not alter the divide cycle in progress. The first cycle with the new ratio starts right after the next `divPulse`.
- R9: From the idle state, if a valid word completes at clock edge E, the first `divPulse` is high during the clock that follows edge E+M.
- R10: If several valid words complete within one divide cycle, the cycle after the next boundary uses the last of them.
- R11: A reset in the middle of a cycle stops the output, returns the block to idle and discards any half-written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output, used as the clock |
| rst | input | 1 | Synchronous reset, active high |
| hiWe | input | 1 | Write strobe for the upper half of the word |
| hiData | input | 7 | Word bits 14:8 |
| loWe | input | 1 | Write strobe for the lower half of the word |
| loData | input | 8 | Word bits 7:0 |
| modSel | output | 1 | Prescaler modulus select, 1 = divide by 17 |
| divPulse | output | 1 | One-clock pulse at the end of each divide cycle |
| wordReject | output | 1 | One-clock flag for a completed word below the minimum |

## Verification
The bench builds the block with its defaults: a 15-bit word, a 4-bit swallow field and a minimum ratio of 240. With these values both ends of the range can be run directly. At 240 the main count is only 15, and at 255 A = M, so the divide-by-17 window covers the whole cycle. At 32767 a single cycle lasts 2047 clocks, which is still short enough to measure several times. The same defaults let the bench cover rejection of 239 and 0, and land word updates in the middle of long and short cycles to observe the boundary handover.

// File: rtl/pswd_pkg.sv
package pswd_pkg;

  // Strobes issued by the control unit to the datapath each clock
  typedef struct packed {
    logic clearSeen;    // a full word was completed this clock
    logic acceptWord;   // completed word is in range: stage it as pending
    logic rejectWord;   // completed word is below the minimum ratio
    logic takePending;  // move the pending word into the counters
    logic restart;      // begin a new divide cycle
  } pswdCtl_t;

endpackage

// File: rtl/pswd_stage.sv
module pswd_stage
  import pswd_pkg::*;
#(
  parameter int WORD_W = 15,
  parameter int LO_W   = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   hiWe,
  input  logic [WORD_W-LO_W-1:0] hiData,
  input  logic                   loWe,
  input  logic [LO_W-1:0]        loData,
  input  pswdCtl_t               ctl,
  output logic [WORD_W-1:0]      candWord,
  output logic                   hiSeen,
  output logic                   loSeen,
  output logic [WORD_W-1:0]      pendWord,
  output logic                   pendFull,
  output logic                   wordReject
);

  localparam int HI_W = WORD_W - LO_W;

  logic [HI_W-1:0] hiReg;
  logic [LO_W-1:0] loReg;

  // Word as it stands after this clock's writes
  assign candWord = {(hiWe ? hiData : hiReg), (loWe ? loData : loReg)};

  always_ff @(posedge clk) begin
    if (rst) begin
      hiReg      <= '0;
      loReg      <= '0;
      hiSeen     <= 1'b0;
      loSeen     <= 1'b0;
      pendWord   <= '0;
      pendFull   <= 1'b0;
      wordReject <= 1'b0;
    end else begin
      if (hiWe) hiReg <= hiData;
      if (loWe) loReg <= loData;

      if (ctl.clearSeen) begin
        hiSeen <= 1'b0;
        loSeen <= 1'b0;
      end else begin
        if (hiWe) hiSeen <= 1'b1;
        if (loWe) loSeen <= 1'b1;
      end

      if (ctl.acceptWord) begin
        pendWord <= candWord;
        pendFull <= 1'b1;
      end else if (ctl.takePending) begin
        pendFull <= 1'b0;
      end

      wordReject <= ctl.rejectWord;
    end
  end

endmodule

// File: rtl/pswd_ctrl.sv
module pswd_ctrl
  import pswd_pkg::*;
#(
  parameter int WORD_W    = 15,
  parameter int MIN_RATIO = 240
) (
  input  logic              hiWe,
  input  logic              loWe,
  input  logic              hiSeen,
  input  logic              loSeen,
  input  logic [WORD_W-1:0] candWord,
  input  logic              pendFull,
  input  logic              atEnd,
  input  logic              running,
  output pswdCtl_t          ctl
);

  localparam logic [WORD_W-1:0] MIN_WORD = WORD_W'(MIN_RATIO);

  logic complete;
  logic inRange;

  assign complete = (hiWe | hiSeen) & (loWe | loSeen);
  assign inRange  = (candWord >= MIN_WORD);

  always_comb begin
    ctl             = '0;
    ctl.clearSeen   = complete;
    ctl.acceptWord  = complete & inRange;
    ctl.rejectWord  = complete & ~inRange;
    ctl.takePending = atEnd & pendFull;
    ctl.restart     = atEnd & (pendFull | running);
  end

endmodule

// File: rtl/pswd_count.sv
module pswd_count
  import pswd_pkg::*;
#(
  parameter int WORD_W    = 15,
  parameter int SWALLOW_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  pswdCtl_t          ctl,
  input  logic [WORD_W-1:0] pendWord,
  output logic              modSel,
  output logic              atEnd,
  output logic              running,
  output logic              divPulse
);

  localparam int MAIN_W = WORD_W - SWALLOW_W;
  localparam logic [MAIN_W-1:0] ONE_M = MAIN_W'(1);
  localparam logic [SWALLOW_W-1:0] ONE_A = SWALLOW_W'(1);

  logic [WORD_W-1:0]    actWord;
  logic [WORD_W-1:0]    nextWord;
  logic [MAIN_W-1:0]    mainCnt;
  logic [SWALLOW_W-1:0] swallowCnt;

  assign nextWord = ctl.takePending ? pendWord : actWord;

  always_ff @(posedge clk) begin
    if (rst) begin
      actWord    <= '0;
      mainCnt    <= '0;
      swallowCnt <= '0;
    end else if (ctl.restart) begin
      actWord    <= nextWord;
      mainCnt    <= nextWord[WORD_W-1:SWALLOW_W] - ONE_M;
      swallowCnt <= nextWord[SWALLOW_W-1:0];
    end else if (mainCnt != '0) begin
      mainCnt <= mainCnt - ONE_M;
      if (swallowCnt != '0) swallowCnt <= swallowCnt - ONE_A;
    end
  end

  assign atEnd    = (mainCnt == '0);
  assign running  = (actWord != '0);
  assign divPulse = atEnd & running;
  assign modSel   = (swallowCnt != '0);

endmodule

// File: rtl/pswd_divider_ctrl.sv
module pswd_divider_ctrl
  import pswd_pkg::*;
#(
  parameter int WORD_W    = 15,
  parameter int LO_W      = 8,
  parameter int SWALLOW_W = 4,
  parameter int MIN_RATIO = 240
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   hiWe,
  input  logic [WORD_W-LO_W-1:0] hiData,
  input  logic                   loWe,
  input  logic [LO_W-1:0]        loData,
  output logic                   modSel,
  output logic                   divPulse,
  output logic                   wordReject
);

  pswdCtl_t          ctl;
  logic [WORD_W-1:0] candWord;
  logic [WORD_W-1:0] pendWord;
  logic              hiSeen;
  logic              loSeen;
  logic              pendFull;
  logic              atEnd;
  logic              running;

  pswd_stage #(.WORD_W(WORD_W), .LO_W(LO_W)) u_stage (
    .clk(clk), .rst(rst),
    .hiWe(hiWe), .hiData(hiData), .loWe(loWe), .loData(loData),
    .ctl(ctl), .candWord(candWord), .hiSeen(hiSeen), .loSeen(loSeen),
    .pendWord(pendWord), .pendFull(pendFull), .wordReject(wordReject)
  );

  pswd_ctrl #(.WORD_W(WORD_W), .MIN_RATIO(MIN_RATIO)) u_ctrl (
    .hiWe(hiWe), .loWe(loWe), .hiSeen(hiSeen), .loSeen(loSeen),
    .candWord(candWord), .pendFull(pendFull), .atEnd(atEnd),
    .running(running), .ctl(ctl)
  );

  pswd_count #(.WORD_W(WORD_W), .SWALLOW_W(SWALLOW_W)) u_count (
    .clk(clk), .rst(rst), .ctl(ctl), .pendWord(pendWord),
    .modSel(modSel), .atEnd(atEnd), .running(running), .divPulse(divPulse)
  );

endmodule

// File: rtl/pswd_checker.sv
module pswd_checker #(
  parameter int MIN_M = 15
) (
  input logic clk,
  input logic rst,
  input logic modSel,
  input logic divPulse,
  input logic wordReject,
  input logic running
);

  logic [15:0] gapCnt;
  logic        seenPulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      gapCnt    <= '0;
      seenPulse <= 1'b0;
    end else if (divPulse) begin
      gapCnt    <= 16'd1;
      seenPulse <= 1'b1;
    end else if (gapCnt != 16'hFFFF) begin
      gapCnt <= gapCnt + 16'd1;
    end
  end

  // R1: reset leaves every output low
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!divPulse && !modSel && !wordReject));

  // R1: no output pulse without an active ratio
  p_idle_no_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    !running |-> !divPulse);

  // R4: the output pulse lasts one clock
  p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
    divPulse |=> !divPulse);

  // R3: the divide-by-17 window opens only at a cycle start
  p_mod_start_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(modSel) |-> ($past(divPulse) || !$past(running)));

  // R3: modulus select stays low while idle
  p_mod_idle_r3: assert property (@(posedge clk) disable iff (rst)
    modSel |-> running);

  // R2: pulses never come closer than the smallest main count
  p_pulse_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (divPulse && seenPulse) |-> (gapCnt >= 16'(MIN_M)));

endmodule

bind pswd_divider_ctrl pswd_checker #(.MIN_M(MIN_RATIO >> SWALLOW_W)) u_chk (
  .clk(clk), .rst(rst), .modSel(modSel), .divPulse(divPulse),
  .wordReject(wordReject), .running(running)
);

// File: tb/tb_pswd_divider_ctrl.sv
`timescale 1ns/1ps
module tb_pswd_divider_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hiWe = 1'b0;
  logic [6:0] hiData = '0;
  logic       loWe = 1'b0;
  logic [7:0] loData = '0;
  logic       modSel;
  logic       divPulse;
  logic       wordReject;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pswd_divider_ctrl dut (
    .clk(clk), .rst(rst), .hiWe(hiWe), .hiData(hiData),
    .loWe(loWe), .loData(loData),
    .modSel(modSel), .divPulse(divPulse), .wordReject(wordReject)
  );

  typedef struct packed {
    logic [14:0] word;
    logic [10:0] expM;
    logic [3:0]  expA;
    logic        expRej;
  } vec_t;

  localparam int N_VEC = 9;
  localparam vec_t VECS [N_VEC] = '{
    '{15'd240,   11'd15,   4'd0,  1'b0},
    '{15'd241,   11'd15,   4'd1,  1'b0},
    '{15'd255,   11'd15,   4'd15, 1'b0},
    '{15'd1000,  11'd62,   4'd8,  1'b0},
    '{15'd4660,  11'd291,  4'd4,  1'b0},
    '{15'd1615,  11'd100,  4'd15, 1'b0},
    '{15'd32767, 11'd2047, 4'd15, 1'b0},
    '{15'd239,   11'd0,    4'd0,  1'b1},
    '{15'd0,     11'd0,    4'd0,  1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; hiWe = 1'b0; loWe = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Drive at a sample point; return one negedge later (after the edge)
  task automatic writeBoth(input logic [14:0] w, output bit rej);
    hiWe = 1'b1; hiData = w[14:8]; loWe = 1'b1; loData = w[7:0];
    @(negedge clk);
    hiWe = 1'b0; loWe = 1'b0;
    rej = wordReject;
  endtask

  task automatic writeHi(input logic [6:0] d);
    hiWe = 1'b1; hiData = d;
    @(negedge clk);
    hiWe = 1'b0;
  endtask

  task automatic writeLo(input logic [7:0] d);
    loWe = 1'b1; loData = d;
    @(negedge clk);
    loWe = 1'b0;
  endtask

  // Counts samples until divPulse is seen, starting with the current one
  task automatic waitPulse(output int waited);
    waited = 1;
    while (!divPulse && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
  endtask

  // Called at a sample where divPulse is high
  task automatic measure(output int per, output int mods, output bit wide);
    per = 0; mods = 0; wide = 1'b0;
    do begin
      @(negedge clk);
      per++;
      if (modSel) mods++;
      if (per == 1 && divPulse) wide = 1'b1;
    end while (!divPulse && per < 5000);
  endtask

  task automatic quietFor(input int n, input string req);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (divPulse || modSel) hits++;
    end
    chk(hits == 0, req, hits, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    bit rej;
    bit wide;
    int k;
    int per;
    int mods;
    int cnt;

    // Table walk: each word from idle, both halves in one clock (R6)
    for (int v = 0; v < N_VEC; v++) begin
      doReset();
      writeBoth(VECS[v].word, rej);
      chk(rej == VECS[v].expRej, "R7 reject flag", rej, VECS[v].expRej);
      if (VECS[v].expRej) begin
        quietFor(60, "R7 rejected word stays idle");
      end else begin
        waitPulse(k);
        chk(k == int'(VECS[v].expM) + 1, "R9/R6 first pulse latency", k, int'(VECS[v].expM) + 1);
        measure(per, mods, wide);
        chk(per == int'(VECS[v].expM), "R2 pulse period", per, int'(VECS[v].expM));
        chk(mods == int'(VECS[v].expA), "R3 divide-by-17 clocks", mods, int'(VECS[v].expA));
        chk(!wide, "R4 pulse width", wide, 0);
        measure(per, mods, wide);
        chk(per == int'(VECS[v].expM), "R2 second period", per, int'(VECS[v].expM));
      end
    end

    // R1: reset state
    doReset();
    chk(!divPulse && !modSel && !wordReject, "R1 outputs after reset",
        {divPulse, modSel, wordReject}, 0);
    quietFor(40, "R1 idle after reset");

    // R5: upper half alone does nothing, then lower half completes 4660
    writeHi(7'd18);
    quietFor(80, "R5 half word ignored");
    writeLo(8'd52);
    waitPulse(k);
    chk(k == 292, "R5 word completed by second half", k, 292);

    // R5/R8: lower half first while running, then upper half mid-cycle
    cnt = 0;
    writeLo(8'd232); cnt++;
    repeat (10) begin @(negedge clk); cnt++; end
    writeHi(7'd3); cnt++;
    while (!divPulse && cnt < 5000) begin @(negedge clk); cnt++; end
    chk(cnt == 291, "R8 current cycle keeps old ratio", cnt, 291);
    measure(per, mods, wide);
    chk(per == 62, "R5 new ratio after boundary", per, 62);
    chk(mods == 8, "R3 new swallow count", mods, 8);

    // R10: two words inside one cycle, the later wins
    cnt = 0;
    writeBoth(15'd32767, rej); cnt++;
    repeat (2) begin @(negedge clk); cnt++; end
    writeBoth(15'd1615, rej); cnt++;
    while (!divPulse && cnt < 5000) begin @(negedge clk); cnt++; end
    chk(cnt == 62, "R10 cycle in progress unchanged", cnt, 62);
    measure(per, mods, wide);
    chk(per == 100, "R10 last word used", per, 100);
    chk(mods == 15, "R10 last swallow count", mods, 15);

    // R7: bad word while running
    writeBoth(15'd200, rej);
    chk(rej, "R7 reject while running", rej, 1);
    waitPulse(k);
    measure(per, mods, wide);
    chk(per == 100, "R7 ratio kept after reject", per, 100);

    // R11: reset mid-cycle discards a staged half
    repeat (10) @(negedge clk);
    writeHi(7'd5);
    doReset();
    @(negedge clk);
    chk(!divPulse && !modSel, "R11 outputs after mid-cycle reset", {divPulse, modSel}, 0);
    writeLo(8'hF0);
    quietFor(80, "R11 staged half discarded");
    writeHi(7'd1);
    waitPulse(k);
    chk(k == 32, "R11 restart after reset", k, 32);

    summary();
  end

endmodule